// File: doc/BRIEF.md
# Qualified Non-Maskable Interrupt Detector

This block watches an asynchronous, active-high non-maskable interrupt line and emits a one-clock request strobe with a fixed vector number. The line is brought into the clock domain by a flop chain. A synchronized rising edge is accepted only under two conditions. The line must have been seen LOW for at least `LOW_MIN` consecutive clocks just before the edge. It must then stay HIGH for at least `HIGH_MIN` consecutive clocks after the edge.

The strobe is raised on the clock after the qualifying HIGH sample. No more than one strobe is produced per HIGH period. There is no acknowledge handshake and no enable or mask input. The vector output always carries the same constant. This lets the interrupt logic downstream treat the strobe as a ready-made request.

Timing in this brief assumes the default configuration: a two-stage synchronizer and a minimum of four clocks for both LOW and HIGH. Edge numbering starts at the first rising clock edge after `rst_ni` is released, which is edge 0.

Top module: `nmi_qualifier`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `req_o` is 0.
- R2: Suppose `nmi_i` is sampled LOW on the four edges before edge e and HIGH on edges e through e+3, and those lows are all at edge 0 or later. Then `req_o` is 1 for exactly the cycle after edge e+5. This is two synchronizer clocks plus four qualifying HIGH samples.
- R3: A rising edge preceded by fewer than four consecutive LOW synchronized samples produces no strobe, however long the line then stays HIGH.
- R4: A HIGH period of fewer than four synchronized samples produces no strobe.
- R5: A HIGH period of any length produces at most one strobe, and the strobe is never asserted on two clocks in a row.
- R6: `vec_o` equals 2 at all times after reset, whatever `nmi_i` does.
- R7: If the line is HIGH when reset is released, it produces no strobe until it has gone LOW for four clocks and then met R2.
- R8: After a rejected short HIGH pulse, the LOW count starts again from zero. A new edge needs four fresh LOW samples taken after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt line, active high |
| req_o | output | 1 | One-clock qualified interrupt request strobe |
| vec_o | output | VEC_W | Fixed interrupt vector number (default 2) |

## Verification
The bench sweeps every pairing of a LOW run of 0 to 7 clocks with a HIGH run of 1 to 7 clocks. This exposes off-by-one thresholds in either direction: a design counting from the wrong sample would fire on a three-clock pulse or miss a four-clock one. A pulse, a short gap and then a long HIGH targets a design that keeps its old LOW count across a rejected pulse; such a design would fire early. Long HIGH periods catch a counter that wraps or re-arms and strobes twice. A reset with the line already HIGH catches a design that treats the post-reset level as a fresh edge.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned NMI_VEC_W   = 8;
  localparam int unsigned NMI_VEC_DEF = 2;
  typedef logic [NMI_VEC_W-1:0] nmi_vec_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/nmi_run_cnt.sv
// Saturating count of consecutive clocks with lvl_i set; clears when lvl_i drops.
module nmi_run_cnt #(
  parameter int unsigned MAX = 4,
  localparam int unsigned W  = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lvl_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!lvl_i)            cnt_q <= '0;
    else if (cnt_q != W'(MAX))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nmi_qualifier.sv
module nmi_qualifier
  import nmi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOW_MIN     = 4,
  parameter int unsigned HIGH_MIN    = 4,
  parameter int unsigned VEC_W       = NMI_VEC_W,
  parameter int unsigned VEC_VAL     = NMI_VEC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned LO_W = $clog2(LOW_MIN + 1);
  localparam int unsigned HI_W = $clog2(HIGH_MIN + 1);

  logic            nmi_s;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            rise, lo_ok, armed_q, armed_d, req_q, req_d;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nmi_i),
    .q_o   (nmi_s)
  );

  nmi_run_cnt #(.MAX(LOW_MIN)) u_lo_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (~nmi_s),
    .cnt_o (lo_cnt)
  );

  nmi_run_cnt #(.MAX(HIGH_MIN)) u_hi_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (nmi_s),
    .cnt_o (hi_cnt)
  );

  // first HIGH sample of a period; LOW run length still visible in lo_cnt
  assign rise  = nmi_s && (hi_cnt == '0);
  assign lo_ok = (lo_cnt >= LO_W'(LOW_MIN));

  always_comb begin
    if (!nmi_s)    armed_d = 1'b0;
    else if (rise) armed_d = lo_ok;
    else           armed_d = armed_q;
  end

  // counter saturation at HIGH_MIN keeps this to one strobe per HIGH period
  assign req_d = nmi_s && (hi_cnt == HI_W'(HIGH_MIN - 1)) && (rise ? lo_ok : armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign req_o = req_q;
  assign vec_o = VEC_W'(VEC_VAL);
endmodule

// File: rtl/nmi_qualifier_chk.sv
module nmi_qualifier_chk #(
  parameter int unsigned LOW_MIN  = 4,
  parameter int unsigned HIGH_MIN = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic s_i,
  input logic req_i
);
  localparam int unsigned LIM = LOW_MIN + HIGH_MIN;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] lo_run, hi_run, lo_cap, cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= '0;
      lo_cap <= '0;
      cyc    <= '0;
    end else begin
      lo_run <= s_i ? '0 : ((lo_run == CW'(LOW_MIN)) ? lo_run : lo_run + 1'b1);
      hi_run <= !s_i ? '0 : ((hi_run == CW'(HIGH_MIN)) ? hi_run : hi_run + 1'b1);
      if (s_i && hi_run == '0) lo_cap <= lo_run;
      if (cyc != CW'(LIM)) cyc <= cyc + 1'b1;
    end
  end

  // R5
  req_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  // R4
  hi_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> hi_run == CW'(HIGH_MIN));

  // R3
  lo_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> lo_cap >= CW'(LOW_MIN));

  // R7
  early_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc < CW'(LIM)) |-> !req_i);
endmodule

bind nmi_qualifier nmi_qualifier_chk #(
  .LOW_MIN (LOW_MIN),
  .HIGH_MIN(HIGH_MIN)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .s_i   (nmi_s),
  .req_i (req_o)
);

// File: tb/sim_nmi_qualifier.sv
`timescale 1ns/1ps
module sim_nmi_qualifier;
  localparam int SYNC = 2;
  localparam int LOWM = 4;
  localparam int HIGM = 4;
  localparam int MAXC = 16384;
  localparam time TCK = 5ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nmi_i = 1'b0;
  logic       req_o;
  logic [7:0] vec_o;

  int  nvec = 0;
  int  nerr = 0;
  int  k    = 0;
  bit  raw [0:MAXC-1];
  bit  done = 1'b0;

  always #(TCK/2) clk_i = ~clk_i;

  nmi_qualifier u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_i (nmi_i),
    .req_o (req_o),
    .vec_o (vec_o)
  );

  function automatic bit sv(int j);
    if (j < SYNC) return 1'b0;
    return raw[j-SYNC];
  endfunction

  function automatic bit exp_req(int e);
    if (e - HIGM - LOWM + 1 < 0) return 1'b0;
    for (int i = 0; i < HIGM; i++) if (!sv(e - i)) return 1'b0;
    for (int i = HIGM; i < HIGM + LOWM; i++) if (sv(e - i)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s edge %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  // drive one edge's worth of nmi_i at a falling edge, check at the next falling edge
  task automatic step(bit v, string tag);
    nmi_i = v;
    raw[k] = v;
    @(negedge clk_i);
    chk(tag, 32'(req_o), 32'(exp_req(k)));
    chk("R6", 32'(vec_o), 32'd2);
    k++;
  endtask

  task automatic run(bit v, int n, string tag);
    for (int i = 0; i < n; i++) step(v, tag);
  endtask

  task automatic do_reset(bit lvl);
    rst_ni = 1'b0;
    nmi_i  = lvl;
    repeat (3) @(negedge clk_i);
    chk("R1", 32'(req_o), 32'd0);
    rst_ni = 1'b1;
    k = 0;
    for (int i = 0; i < MAXC; i++) raw[i] = 1'b0;
  endtask

  initial begin
    #(TCK * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int strobes;
    logic [15:0] lfsr;
    @(negedge clk_i);
    do_reset(1'b0);
    run(1'b0, 2, "R1");

    // R2 R3 R4: sweep LOW/HIGH run lengths
    for (int lo = 0; lo < 8; lo++) begin
      for (int hi = 1; hi < 8; hi++) begin
        run(1'b1, 6, "R5");
        run(1'b0, lo, "R3");
        run(1'b1, hi, (lo < LOWM) ? "R3" : ((hi < HIGM) ? "R4" : "R2"));
        run(1'b0, 6, "R2");
      end
    end

    // R8: rejected pulse, short gap, then long HIGH must not fire
    run(1'b0, 8, "R8");
    run(1'b1, 2, "R8");
    run(1'b0, 3, "R8");
    strobes = 0;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, "R8");
      strobes += int'(req_o);
    end
    chk("R8", 32'(strobes), 32'd0);

    // R5: long qualified HIGH gives exactly one strobe
    run(1'b0, 6, "R5");
    strobes = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, "R5");
      strobes += int'(req_o);
    end
    chk("R5", 32'(strobes), 32'd1);
    run(1'b0, 3, "R5");

    // R7: line HIGH at reset
    do_reset(1'b1);
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, "R7");
      strobes += int'(req_o);
    end
    chk("R7", 32'(strobes), 32'd0);
    run(1'b0, 4, "R7");
    run(1'b1, 8, "R7");

    // R2: pseudo-random stream with long runs
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[3:0] < 4'd6) ? ~raw[(k > 0) ? k-1 : 0] : raw[(k > 0) ? k-1 : 0], "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule